// File: doc/BRIEF.md
# DDR PHY Command Injector

This block sits on the path between a DRAM controller and a multi-phase DDR PHY port. A small byte-wide register bus lets a processor take the PHY port away from the controller and drive raw SDRAM commands by hand. Typical uses are the power-up and mode-register sequence, and single reads and writes during bring-up. A control register selects which side owns the port and sets the clock-enable pin.

Each phase of the PHY interface has its own registers for the command, row/column address, bank and write data, and its own issue strobe. Writing the strobe drives the stored command on that phase for one cycle. When that command carries the read-data flag, the next read-valid beat from the PHY on that phase is captured into per-phase read-data registers. Software can then fetch these bytes over the same bus.

When the controller owns the port, every controller signal reaches the PHY unchanged in the same cycle, and software command issue has no effect.

Top module: `ddr_cmd_injector`

## Requirements
- R1: After reset, software owns the port (select bit 0), clock enable is 0, all active-low command pins of every phase are high, both data-enable outputs are low, addresses and banks are zero, and every register reads 0.
- R2: The register at address 0x00 holds the select bit in bit 0 and the clock-enable bit in bit 1. `phy_cke` equals bit 1 from the cycle after the write, whoever owns the port.
- R3: With select = 1, every PHY command, address, bank, write-data and enable output equals the matching controller input in the same cycle. `ctl_rddata_valid` follows `phy_rddata_valid`. A write to any issue strobe is ignored.
- R4: With select = 0, `phy_addr` of a phase is {high byte, low byte} of that phase's address registers, `phy_bank` is its bank register, `phy_wrdata` comes from its write-data registers, and `ctl_rddata_valid` is 0.
- R5: Phase p owns register addresses 0x20·(p+1) to 0x20·(p+1)+0x1F. The command register is at offset 0, with bit0 chip select, bit1 write enable, bit2 column strobe, bit3 row strobe, bit4 write-data flag and bit5 read-data flag. A write of any value to offset 1 (issue), with select = 0, drives low the pins whose command bits are set, for exactly the next cycle. All command pins are high in every other cycle.
- R6: In the cycle of an issued command, `phy_wrdata_en` and `phy_rddata_en` of that phase equal command bits 4 and 5. They are 0 otherwise.
- R7: Issuing on one phase leaves the command and enable outputs of the other phases at their idle values.
- R8: After an issued command with the read-data flag, the first later cycle with `phy_rddata_valid` high on that phase stores `phy_rddata` of that phase in its read-data registers. Later valid beats are ignored until the next such read.
- R9: `reg_rdata` shows the register at `reg_raddr` combinationally: control at 0x00, and at phase offsets 0 (command), 2 (address high byte), 3 (address low byte), 4 (bank), 8+i (write byte i) and 16+i (read byte i). Offset 1 and every unmapped address read 0. Writes to read-data offsets are ignored.
- R10: Write byte i of a phase drives bits [8i+7:8i] of that phase's `phy_wrdata`. Read byte i is taken from the same bits of `phy_rddata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 7 | Register read address |
| reg_rdata | output | 8 | Register read data (combinational) |
| ctl_addr | input | NPHASES×ADDR_W | Controller address per phase |
| ctl_bank | input | NPHASES×BANK_W | Controller bank per phase |
| ctl_cs_n | input | NPHASES | Controller chip select, active low |
| ctl_ras_n | input | NPHASES | Controller row strobe, active low |
| ctl_cas_n | input | NPHASES | Controller column strobe, active low |
| ctl_we_n | input | NPHASES | Controller write enable, active low |
| ctl_wrdata_en | input | NPHASES | Controller write-data enable |
| ctl_wrdata | input | NPHASES×8·NBYTES | Controller write data |
| ctl_rddata_en | input | NPHASES | Controller read-data enable |
| ctl_rddata | output | NPHASES×8·NBYTES | Read data passed to controller |
| ctl_rddata_valid | output | NPHASES | Read-valid passed to controller |
| phy_cke | output | 1 | Clock enable |
| phy_addr | output | NPHASES×ADDR_W | PHY address per phase |
| phy_bank | output | NPHASES×BANK_W | PHY bank per phase |
| phy_cs_n | output | NPHASES | PHY chip select, active low |
| phy_ras_n | output | NPHASES | PHY row strobe, active low |
| phy_cas_n | output | NPHASES | PHY column strobe, active low |
| phy_we_n | output | NPHASES | PHY write enable, active low |
| phy_wrdata_en | output | NPHASES | PHY write-data enable |
| phy_wrdata | output | NPHASES×8·NBYTES | PHY write data |
| phy_rddata_en | output | NPHASES | PHY read-data enable |
| phy_rddata | input | NPHASES×8·NBYTES | PHY read data |
| phy_rddata_valid | input | NPHASES | PHY read-data valid |

## Verification
The bench uses the default build: two phases, a 16-bit address, a 3-bit bank and eight data bytes per phase. With these values, the per-phase address windows at 0x20 and 0x40, phase independence and the full 64-bit byte order on both phases can all be reached. Ownership is flipped between controller and software several times during random register traffic, so issue strobes meet both owners and capture windows meet stray valid beats.

// File: rtl/ddrinj_pkg.sv
package ddrinj_pkg;

    localparam int REG_AW       = 7;
    localparam int OFS_W        = 5;
    localparam int PHASE_STRIDE = 1 << OFS_W;

    localparam logic [OFS_W-1:0] OFS_CMD   = 5'd0;
    localparam logic [OFS_W-1:0] OFS_ISSUE = 5'd1;
    localparam logic [OFS_W-1:0] OFS_AHI   = 5'd2;
    localparam logic [OFS_W-1:0] OFS_ALO   = 5'd3;
    localparam logic [OFS_W-1:0] OFS_BANK  = 5'd4;
    localparam int               OFS_WD    = 8;
    localparam int               OFS_RD    = 16;

    localparam logic [REG_AW-1:0] CTRL_ADDR = '0;
    localparam int CTRL_SEL_BIT = 0;
    localparam int CTRL_CKE_BIT = 1;

    typedef struct packed {
        logic rddata;
        logic wrdata;
        logic ras;
        logic cas;
        logic we;
        logic cs;
    } inj_cmd_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic wr_en;
        logic rd_en;
    } pin_set_t;

    localparam pin_set_t PINS_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                       we_n: 1'b1, wr_en: 1'b0, rd_en: 1'b0};

    function automatic logic [REG_AW-1:0] phase_base(input int p);
        return REG_AW'((p + 1) * PHASE_STRIDE);
    endfunction

    function automatic pin_set_t drive_pins(input inj_cmd_t c, input logic fire);
        pin_set_t s;
        s.cs_n  = !(fire && c.cs);
        s.ras_n = !(fire && c.ras);
        s.cas_n = !(fire && c.cas);
        s.we_n  = !(fire && c.we);
        s.wr_en = fire && c.wrdata;
        s.rd_en = fire && c.rddata;
        return s;
    endfunction

endpackage

// File: rtl/ddrinj_ctrl.sv
module ddrinj_ctrl
    import ddrinj_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic              sel,
    output logic              cke
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= 1'b0;
            cke <= 1'b0;
        end else if (reg_we && reg_addr == CTRL_ADDR) begin
            sel <= reg_wdata[CTRL_SEL_BIT];
            cke <= reg_wdata[CTRL_CKE_BIT];
        end
    end
endmodule

// File: rtl/ddrinj_phase.sv
module ddrinj_phase
    import ddrinj_pkg::*;
#(
    parameter int PHASE  = 0,
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int NBYTES = 8,
    localparam int DW    = NBYTES * 8,
    localparam int HI_W  = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic [REG_AW-1:0] reg_raddr,
    input  logic              sel,
    input  logic [DW-1:0]     phy_rddata,
    input  logic              phy_rddata_valid,
    output logic [ADDR_W-1:0] sw_addr,
    output logic [BANK_W-1:0] sw_bank,
    output logic [DW-1:0]     sw_wrdata,
    output pin_set_t          sw_pins,
    output logic [7:0]        rd_byte
);
    localparam logic [REG_AW-1:0] BASE = phase_base(PHASE);

    inj_cmd_t                cmd_q;
    logic [HI_W-1:0]         ahi_q;
    logic [7:0]              alo_q;
    logic [BANK_W-1:0]       bank_q;
    logic [NBYTES-1:0][7:0]  wd_q;
    logic [NBYTES-1:0][7:0]  rd_q;
    logic                    pulse_q;
    logic                    pend_q;

    logic             wr_hit;
    logic             rd_hit;
    logic [OFS_W-1:0] wofs;
    logic [OFS_W-1:0] rofs;

    assign wr_hit = reg_we && (reg_addr[REG_AW-1:OFS_W] == BASE[REG_AW-1:OFS_W]);
    assign rd_hit = (reg_raddr[REG_AW-1:OFS_W] == BASE[REG_AW-1:OFS_W]);
    assign wofs   = reg_addr[OFS_W-1:0];
    assign rofs   = reg_raddr[OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            ahi_q   <= '0;
            alo_q   <= '0;
            bank_q  <= '0;
            wd_q    <= '0;
            rd_q    <= '0;
            pulse_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (wr_hit) begin
                case (wofs)
                    OFS_CMD:  cmd_q  <= inj_cmd_t'(reg_wdata[5:0]);
                    OFS_AHI:  ahi_q  <= reg_wdata[HI_W-1:0];
                    OFS_ALO:  alo_q  <= reg_wdata;
                    OFS_BANK: bank_q <= reg_wdata[BANK_W-1:0];
                    default:  ;
                endcase
            end
            for (int i = 0; i < NBYTES; i++) begin
                if (wr_hit && int'(wofs) == OFS_WD + i) wd_q[i] <= reg_wdata;
            end
            pulse_q <= wr_hit && (wofs == OFS_ISSUE) && !sel;
            if (pend_q && phy_rddata_valid) begin
                rd_q   <= phy_rddata;
                pend_q <= 1'b0;
            end
            if (pulse_q && cmd_q.rddata) pend_q <= 1'b1;
        end
    end

    assign sw_addr   = {ahi_q, alo_q};
    assign sw_bank   = bank_q;
    assign sw_wrdata = wd_q;
    assign sw_pins   = drive_pins(cmd_q, pulse_q);

    always_comb begin
        rd_byte = '0;
        if (rd_hit) begin
            case (rofs)
                OFS_CMD:  rd_byte = 8'(cmd_q);
                OFS_AHI:  rd_byte = 8'(ahi_q);
                OFS_ALO:  rd_byte = alo_q;
                OFS_BANK: rd_byte = 8'(bank_q);
                default:  ;
            endcase
            for (int i = 0; i < NBYTES; i++) begin
                if (int'(rofs) == OFS_WD + i) rd_byte = wd_q[i];
                if (int'(rofs) == OFS_RD + i) rd_byte = rd_q[i];
            end
        end
    end
endmodule

// File: rtl/ddrinj_mux.sv
module ddrinj_mux
    import ddrinj_pkg::*;
#(
    parameter int NPHASES = 2,
    parameter int ADDR_W  = 16,
    parameter int BANK_W  = 3,
    parameter int DW      = 64
) (
    input  logic                           sel,
    input  logic [NPHASES-1:0][ADDR_W-1:0] ctl_addr,
    input  logic [NPHASES-1:0][BANK_W-1:0] ctl_bank,
    input  pin_set_t [NPHASES-1:0]         ctl_pins,
    input  logic [NPHASES-1:0][DW-1:0]     ctl_wrdata,
    input  logic [NPHASES-1:0][ADDR_W-1:0] sw_addr,
    input  logic [NPHASES-1:0][BANK_W-1:0] sw_bank,
    input  pin_set_t [NPHASES-1:0]         sw_pins,
    input  logic [NPHASES-1:0][DW-1:0]     sw_wrdata,
    output logic [NPHASES-1:0][ADDR_W-1:0] phy_addr,
    output logic [NPHASES-1:0][BANK_W-1:0] phy_bank,
    output pin_set_t [NPHASES-1:0]         phy_pins,
    output logic [NPHASES-1:0][DW-1:0]     phy_wrdata
);
    for (genvar p = 0; p < NPHASES; p++) begin : g_sel
        assign phy_addr[p]   = sel ? ctl_addr[p]   : sw_addr[p];
        assign phy_bank[p]   = sel ? ctl_bank[p]   : sw_bank[p];
        assign phy_pins[p]   = sel ? ctl_pins[p]   : sw_pins[p];
        assign phy_wrdata[p] = sel ? ctl_wrdata[p] : sw_wrdata[p];
    end
endmodule

// File: rtl/ddr_cmd_injector.sv
module ddr_cmd_injector
    import ddrinj_pkg::*;
#(
    parameter int NPHASES = 2,
    parameter int ADDR_W  = 16,
    parameter int BANK_W  = 3,
    parameter int NBYTES  = 8,
    localparam int DW     = NBYTES * 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           reg_we,
    input  logic [REG_AW-1:0]              reg_addr,
    input  logic [7:0]                     reg_wdata,
    input  logic [REG_AW-1:0]              reg_raddr,
    output logic [7:0]                     reg_rdata,
    input  logic [NPHASES-1:0][ADDR_W-1:0] ctl_addr,
    input  logic [NPHASES-1:0][BANK_W-1:0] ctl_bank,
    input  logic [NPHASES-1:0]             ctl_cs_n,
    input  logic [NPHASES-1:0]             ctl_ras_n,
    input  logic [NPHASES-1:0]             ctl_cas_n,
    input  logic [NPHASES-1:0]             ctl_we_n,
    input  logic [NPHASES-1:0]             ctl_wrdata_en,
    input  logic [NPHASES-1:0][DW-1:0]     ctl_wrdata,
    input  logic [NPHASES-1:0]             ctl_rddata_en,
    output logic [NPHASES-1:0][DW-1:0]     ctl_rddata,
    output logic [NPHASES-1:0]             ctl_rddata_valid,
    output logic                           phy_cke,
    output logic [NPHASES-1:0][ADDR_W-1:0] phy_addr,
    output logic [NPHASES-1:0][BANK_W-1:0] phy_bank,
    output logic [NPHASES-1:0]             phy_cs_n,
    output logic [NPHASES-1:0]             phy_ras_n,
    output logic [NPHASES-1:0]             phy_cas_n,
    output logic [NPHASES-1:0]             phy_we_n,
    output logic [NPHASES-1:0]             phy_wrdata_en,
    output logic [NPHASES-1:0][DW-1:0]     phy_wrdata,
    output logic [NPHASES-1:0]             phy_rddata_en,
    input  logic [NPHASES-1:0][DW-1:0]     phy_rddata,
    input  logic [NPHASES-1:0]             phy_rddata_valid
);
    logic sel_w;
    logic cke_w;

    logic [NPHASES-1:0][ADDR_W-1:0] sw_addr;
    logic [NPHASES-1:0][BANK_W-1:0] sw_bank;
    logic [NPHASES-1:0][DW-1:0]     sw_wrdata;
    pin_set_t [NPHASES-1:0]         sw_pins;
    pin_set_t [NPHASES-1:0]         ctl_pins;
    pin_set_t [NPHASES-1:0]         phy_pins;
    logic [NPHASES-1:0][7:0]        ph_rd;

    ddrinj_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .sel       (sel_w),
        .cke       (cke_w)
    );

    for (genvar p = 0; p < NPHASES; p++) begin : g_ph
        ddrinj_phase #(
            .PHASE  (p),
            .ADDR_W (ADDR_W),
            .BANK_W (BANK_W),
            .NBYTES (NBYTES)
        ) u_ph (
            .clk              (clk),
            .rst              (rst),
            .reg_we           (reg_we),
            .reg_addr         (reg_addr),
            .reg_wdata        (reg_wdata),
            .reg_raddr        (reg_raddr),
            .sel              (sel_w),
            .phy_rddata       (phy_rddata[p]),
            .phy_rddata_valid (phy_rddata_valid[p]),
            .sw_addr          (sw_addr[p]),
            .sw_bank          (sw_bank[p]),
            .sw_wrdata        (sw_wrdata[p]),
            .sw_pins          (sw_pins[p]),
            .rd_byte          (ph_rd[p])
        );

        assign ctl_pins[p] = '{cs_n: ctl_cs_n[p], ras_n: ctl_ras_n[p],
                               cas_n: ctl_cas_n[p], we_n: ctl_we_n[p],
                               wr_en: ctl_wrdata_en[p], rd_en: ctl_rddata_en[p]};

        assign phy_cs_n[p]      = phy_pins[p].cs_n;
        assign phy_ras_n[p]     = phy_pins[p].ras_n;
        assign phy_cas_n[p]     = phy_pins[p].cas_n;
        assign phy_we_n[p]      = phy_pins[p].we_n;
        assign phy_wrdata_en[p] = phy_pins[p].wr_en;
        assign phy_rddata_en[p] = phy_pins[p].rd_en;
    end

    ddrinj_mux #(
        .NPHASES (NPHASES),
        .ADDR_W  (ADDR_W),
        .BANK_W  (BANK_W),
        .DW      (DW)
    ) u_mux (
        .sel        (sel_w),
        .ctl_addr   (ctl_addr),
        .ctl_bank   (ctl_bank),
        .ctl_pins   (ctl_pins),
        .ctl_wrdata (ctl_wrdata),
        .sw_addr    (sw_addr),
        .sw_bank    (sw_bank),
        .sw_pins    (sw_pins),
        .sw_wrdata  (sw_wrdata),
        .phy_addr   (phy_addr),
        .phy_bank   (phy_bank),
        .phy_pins   (phy_pins),
        .phy_wrdata (phy_wrdata)
    );

    assign phy_cke          = cke_w;
    assign ctl_rddata       = phy_rddata;
    assign ctl_rddata_valid = sel_w ? phy_rddata_valid : '0;

    always_comb begin
        reg_rdata = '0;
        if (reg_raddr == CTRL_ADDR) begin
            reg_rdata[CTRL_SEL_BIT] = sel_w;
            reg_rdata[CTRL_CKE_BIT] = cke_w;
        end
        for (int p = 0; p < NPHASES; p++) reg_rdata = reg_rdata | ph_rd[p];
    end
endmodule

// File: rtl/ddrinj_chk.sv
module ddrinj_chk
    import ddrinj_pkg::*;
#(
    parameter int NPHASES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sel,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              phy_cke,
    input logic [NPHASES-1:0] phy_cs_n,
    input logic [NPHASES-1:0] phy_ras_n,
    input logic [NPHASES-1:0] phy_cas_n,
    input logic [NPHASES-1:0] phy_we_n,
    input logic [NPHASES-1:0] phy_wrdata_en,
    input logic [NPHASES-1:0] phy_rddata_en,
    input logic [NPHASES-1:0] ctl_cs_n,
    input logic [NPHASES-1:0] ctl_ras_n,
    input logic [NPHASES-1:0] ctl_cas_n,
    input logic [NPHASES-1:0] ctl_we_n,
    input logic [NPHASES-1:0] phy_rddata_valid,
    input logic [NPHASES-1:0] ctl_rddata_valid
);
    AST_CKE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == CTRL_ADDR) |=> (phy_cke == $past(reg_wdata[CTRL_CKE_BIT]))); // R2

    AST_CTL_OWNS_PINS: assert property (@(posedge clk) disable iff (rst)
        sel |-> (phy_cs_n == ctl_cs_n && phy_ras_n == ctl_ras_n &&
                 phy_cas_n == ctl_cas_n && phy_we_n == ctl_we_n)); // R3

    AST_VALID_GATED: assert property (@(posedge clk) disable iff (rst)
        !sel |-> (ctl_rddata_valid == '0)); // R4

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        sel |-> (ctl_rddata_valid == phy_rddata_valid)); // R3

    for (genvar p = 0; p < NPHASES; p++) begin : g_idle
        localparam logic [REG_AW-1:0] ISSUE_A = phase_base(p) + REG_AW'(OFS_ISSUE);
        AST_IDLE_NOP: assert property (@(posedge clk) disable iff (rst)
            (!sel && !($past(reg_we) && $past(reg_addr) == ISSUE_A && !$past(sel)))
            |-> (phy_cs_n[p] && phy_ras_n[p] && phy_cas_n[p] && phy_we_n[p] &&
                 !phy_wrdata_en[p] && !phy_rddata_en[p])); // R5
    end
endmodule

bind ddr_cmd_injector ddrinj_chk #(.NPHASES(NPHASES)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .sel              (sel_w),
    .reg_we           (reg_we),
    .reg_addr         (reg_addr),
    .reg_wdata        (reg_wdata),
    .phy_cke          (phy_cke),
    .phy_cs_n         (phy_cs_n),
    .phy_ras_n        (phy_ras_n),
    .phy_cas_n        (phy_cas_n),
    .phy_we_n         (phy_we_n),
    .phy_wrdata_en    (phy_wrdata_en),
    .phy_rddata_en    (phy_rddata_en),
    .ctl_cs_n         (ctl_cs_n),
    .ctl_ras_n        (ctl_ras_n),
    .ctl_cas_n        (ctl_cas_n),
    .ctl_we_n         (ctl_we_n),
    .phy_rddata_valid (phy_rddata_valid),
    .ctl_rddata_valid (ctl_rddata_valid)
);

// File: tb/ddr_cmd_injector_tb.sv
module ddr_cmd_injector_tb;
    localparam int NP = 2;
    localparam int AW = 16;
    localparam int BW = 3;
    localparam int NB = 8;
    localparam int DW = NB * 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              reg_we = 1'b0;
    logic [6:0]        reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [6:0]        reg_raddr = '0;
    logic [7:0]        reg_rdata;
    logic [NP-1:0][AW-1:0] ctl_addr;
    logic [NP-1:0][BW-1:0] ctl_bank;
    logic [NP-1:0]     ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n, ctl_wrdata_en, ctl_rddata_en;
    logic [NP-1:0][DW-1:0] ctl_wrdata;
    logic [NP-1:0][DW-1:0] ctl_rddata;
    logic [NP-1:0]     ctl_rddata_valid;
    logic              phy_cke;
    logic [NP-1:0][AW-1:0] phy_addr;
    logic [NP-1:0][BW-1:0] phy_bank;
    logic [NP-1:0]     phy_cs_n, phy_ras_n, phy_cas_n, phy_we_n, phy_wrdata_en, phy_rddata_en;
    logic [NP-1:0][DW-1:0] phy_wrdata;
    logic [NP-1:0][DW-1:0] phy_rddata = '0;
    logic [NP-1:0]     phy_rddata_valid = '0;

    ddr_cmd_injector u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit run_cmp = 1'b0;

    // behavioural reference state
    bit        m_sel, m_cke;
    bit [5:0]  m_cmd [NP];
    bit [7:0]  m_ah [NP], m_al [NP], m_bank [NP];
    bit [7:0]  m_wd [NP][NB];
    bit [7:0]  m_rd [NP][NB];
    bit        m_pulse [NP], m_pend [NP];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] mread(input int a);
        int p, o;
        if (a == 0) return {6'd0, m_cke, m_sel};
        p = a / 32 - 1;
        o = a % 32;
        if (p < 0 || p >= NP) return 8'h00;
        if (o == 0) return {2'b00, m_cmd[p]};
        if (o == 2) return m_ah[p];
        if (o == 3) return m_al[p];
        if (o == 4) return m_bank[p];
        if (o >= 8 && o < 8 + NB) return m_wd[p][o-8];
        if (o >= 16 && o < 16 + NB) return m_rd[p][o-16];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sel = 0; m_cke = 0;
            for (int p = 0; p < NP; p++) begin
                m_cmd[p] = 0; m_ah[p] = 0; m_al[p] = 0; m_bank[p] = 0;
                m_pulse[p] = 0; m_pend[p] = 0;
                for (int i = 0; i < NB; i++) begin m_wd[p][i] = 0; m_rd[p][i] = 0; end
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                bit set_pend;
                set_pend = m_pulse[p] && m_cmd[p][5];
                if (m_pend[p] && phy_rddata_valid[p]) begin
                    for (int i = 0; i < NB; i++) m_rd[p][i] = phy_rddata[p][8*i +: 8];
                    m_pend[p] = 0;
                end
                if (set_pend) m_pend[p] = 1;
                m_pulse[p] = reg_we && (int'(reg_addr) == 32*(p+1) + 1) && !m_sel;
            end
            if (reg_we) begin
                int a, p, o;
                a = int'(reg_addr);
                p = a / 32 - 1;
                o = a % 32;
                if (a == 0) begin m_sel = reg_wdata[0]; m_cke = reg_wdata[1]; end
                else if (p >= 0 && p < NP) begin
                    if (o == 0) m_cmd[p] = reg_wdata[5:0];
                    if (o == 2) m_ah[p] = reg_wdata;
                    if (o == 3) m_al[p] = reg_wdata;
                    if (o == 4) m_bank[p] = {5'd0, reg_wdata[2:0]};
                    if (o >= 8 && o < 8 + NB) m_wd[p][o-8] = reg_wdata;
                end
            end
        end
    end

    // random controller traffic
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) begin
            ctl_addr[p]   = AW'($urandom);
            ctl_bank[p]   = BW'($urandom);
            ctl_wrdata[p] = {$urandom, $urandom};
        end
        {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n, ctl_wrdata_en, ctl_rddata_en} = 12'($urandom);
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (run_cmp && !rst) begin
            check("R2 cke", 64'(phy_cke), 64'(m_cke));
            check("R9 readback", 64'(reg_rdata), 64'(mread(int'(reg_raddr))));
            for (int p = 0; p < NP; p++) begin
                logic [5:0] ep;
                logic [DW-1:0] ewd;
                for (int i = 0; i < NB; i++) ewd[8*i +: 8] = m_wd[p][i];
                if (m_sel) begin
                    ep = {ctl_cs_n[p], ctl_ras_n[p], ctl_cas_n[p], ctl_we_n[p], ctl_wrdata_en[p], ctl_rddata_en[p]};
                    check("R3 pins", 64'({phy_cs_n[p], phy_ras_n[p], phy_cas_n[p], phy_we_n[p], phy_wrdata_en[p], phy_rddata_en[p]}), 64'(ep));
                    check("R3 addr", 64'({phy_addr[p], phy_bank[p]}), 64'({ctl_addr[p], ctl_bank[p]}));
                    check("R3 wrdata", phy_wrdata[p], ctl_wrdata[p]);
                    check("R3 valid", 64'(ctl_rddata_valid[p]), 64'(phy_rddata_valid[p]));
                end else begin
                    ep[5] = !(m_pulse[p] && m_cmd[p][0]);
                    ep[4] = !(m_pulse[p] && m_cmd[p][3]);
                    ep[3] = !(m_pulse[p] && m_cmd[p][2]);
                    ep[2] = !(m_pulse[p] && m_cmd[p][1]);
                    ep[1] = m_pulse[p] && m_cmd[p][4];
                    ep[0] = m_pulse[p] && m_cmd[p][5];
                    check("R5 pins", 64'({phy_cs_n[p], phy_ras_n[p], phy_cas_n[p], phy_we_n[p]}), 64'(ep[5:2]));
                    check("R6 enables", 64'({phy_wrdata_en[p], phy_rddata_en[p]}), 64'(ep[1:0]));
                    check("R4 addr", 64'({phy_addr[p], phy_bank[p]}), 64'({m_ah[p], m_al[p], m_bank[p][2:0]}));
                    check("R4 R10 wrdata", phy_wrdata[p], ewd);
                    check("R4 valid", 64'(ctl_rddata_valid[p]), 64'd0);
                end
                check("R3 rddata pass", ctl_rddata[p], phy_rddata[p]);
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 7'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        reg_raddr = 7'(a);
        #2;
        check(req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        // R1 reset state
        check("R1 cke", 64'(phy_cke), 64'd0);
        check("R1 pins", 64'({phy_cs_n, phy_ras_n, phy_cas_n, phy_we_n}), 64'hFF);
        check("R1 enables", 64'({phy_wrdata_en, phy_rddata_en}), 64'd0);
        check("R1 addr", 64'({phy_addr, phy_bank}), 64'd0);
        rd_chk("R1 ctrl reg", 0, 0);
        rd_chk("R1 cmd reg", 32, 0);
        run_cmp = 1'b1;

        wr(0, 8'h02);
        #2 check("R2 cke on", 64'(phy_cke), 64'd1);

        // precharge-like command on phase 0
        wr(32 + 2, 8'h04);
        wr(32 + 3, 8'h00);
        wr(32 + 4, 8'h00);
        wr(32 + 0, 8'h0B);
        wr(32 + 1, 8'h01);
        #2;
        check("R5 issue pins", 64'({phy_cs_n[0], phy_ras_n[0], phy_cas_n[0], phy_we_n[0]}), 64'b0010);
        check("R7 other phase idle", 64'({phy_cs_n[1], phy_ras_n[1], phy_cas_n[1], phy_we_n[1], phy_wrdata_en[1], phy_rddata_en[1]}), 64'b111100);
        check("R4 addr", 64'(phy_addr[0]), 64'h0400);
        @(negedge clk); #2;
        check("R5 back to nop", 64'({phy_cs_n[0], phy_ras_n[0], phy_cas_n[0], phy_we_n[0]}), 64'hF);

        // write on phase 1
        for (int i = 0; i < NB; i++) wr(64 + 8 + i, 8'hF0 + i);
        wr(64 + 0, 8'h17);
        wr(64 + 1, 8'h00);
        #2;
        check("R6 wrdata_en", 64'({phy_wrdata_en[1], phy_rddata_en[1]}), 64'b10);
        check("R10 byte order", phy_wrdata[1], 64'hF7F6F5F4F3F2F1F0);
        check("R7 phase0 idle", 64'(phy_cs_n[0]), 64'd1);

        // read on phase 0 and capture
        wr(32 + 0, 8'h25);
        wr(32 + 1, 8'h00);
        #2 check("R6 rddata_en", 64'(phy_rddata_en[0]), 64'd1);
        @(negedge clk);
        phy_rddata[0] = 64'h1122334455667788;
        phy_rddata_valid[0] = 1'b1;
        @(negedge clk);
        phy_rddata[0] = 64'hDEADBEEFCAFEF00D;
        @(negedge clk);
        phy_rddata_valid[0] = 1'b0;
        rd_chk("R8 R10 read byte0", 32 + 16, 8'h88);
        rd_chk("R8 read byte7", 32 + 23, 8'h11);
        wr(32 + 16, 8'h55);
        rd_chk("R9 read reg not writable", 32 + 16, 8'h88);
        rd_chk("R9 unmapped", 5, 0);
        rd_chk("R9 issue offset", 33, 0);

        // controller owns the port
        wr(0, 8'h03);
        wr(32 + 1, 8'h00);
        #2 check("R3 issue ignored", 64'(phy_cs_n[0]), 64'(ctl_cs_n[0]));
        check("R3 addr pass", 64'(phy_addr[1]), 64'(ctl_addr[1]));
        check("R2 cke with sel", 64'(phy_cke), 64'd1);
        wr(0, 8'h02);

        // random register traffic
        for (int n = 0; n < 3000; n++) begin
            int r, p, o;
            @(negedge clk);
            r = $urandom % 12;
            p = $urandom % NP;
            o = $urandom % 24;
            reg_we = ($urandom % 3) != 0;
            if (r == 0) begin
                reg_addr = 7'd0;
                reg_wdata = {6'd0, 1'($urandom), (($urandom % 4) == 0)};
            end else begin
                reg_addr = 7'(32*(p+1) + o);
                reg_wdata = 8'($urandom);
            end
            reg_raddr = 7'($urandom % 96);
            for (int q = 0; q < NP; q++) begin
                phy_rddata[q] = {$urandom, $urandom};
                phy_rddata_valid[q] = ($urandom % 4) == 0;
            end
        end
        @(negedge clk);
        reg_we = 1'b0;
        phy_rddata_valid = '0;
        repeat (3) @(negedge clk);
        #2;
        finish_run();
    end
endmodule